// File: doc/BRIEF.md
# Power-Budget Subtask Issue Arbiter

This block sits in front of a group of in-memory processing units. It holds a small table of pending subtasks. Each subtask names the unit that runs it, the power it draws while running, and the table slots whose subtasks must finish before it may start. Each cycle a single arbiter looks at the table. It fires a one-cycle start pulse to a unit when that subtask's predecessors have all finished and the remaining power budget covers its cost. The cost is charged against the budget when the start pulse fires. It is credited back when the unit pulses done.

A subtask whose turn comes but cannot be powered is placed in a replay queue. The queue is drained strictly in arrival order before any other subtask is considered, so a costly subtask cannot be starved by a stream of cheap ones. The budget cap is an input. It is taken into the block only while no subtask is running, so the charge and credit accounting always works against one fixed cap.

Top module: `pwr_issue_arb`

## Requirements
- R1: While reset is held and in the first cycle after it, no start pulse is asserted, `sub_ready` is 1, `sub_slot` is 0 and `avail` is 0.
- R2: A subtask offered while `sub_ready` is 1 is written into the lowest-numbered free slot, which `sub_slot` shows. `sub_ready` is 0 when all slots are occupied.
- R3: At most one bit of `start` is high in any cycle. A unit that already has a running subtask receives no further start until it reports done.
- R4: A subtask does not start while any slot named in its dependency mask (bit i = slot i) still holds a subtask. Mask bits for slots that are empty when the subtask is written are dropped.
- R5: A subtask starts only if its cost is at most the budget available in that cycle. `avail` falls by that cost on the cycle after the start pulse.
- R6: A subtask that is ready but cannot start — because its cost exceeds the budget, or because the replay queue is not empty — joins the replay queue. While the queue is not empty, only its head may start. Subtasks leave the queue in the order they joined.
- R7: A done pulse for a unit with a running subtask frees that slot and credits its cost to `avail` at the next edge. In the same edge it clears that slot from every other subtask's dependency mask, so a dependant can start in the following cycle.
- R8: `cap_in` is taken as the cap, and loaded into `avail`, only in cycles when no subtask is running. Changes to it while subtasks run have no effect on `avail`.
- R9: The summed cost of all running subtasks never exceeds the cap.
- R10: A done pulse for a unit with no running subtask has no effect on `avail` or on any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | COST_W | Power cap, taken while no subtask runs |
| sub_valid | input | 1 | Offer of a new subtask |
| sub_unit | input | UNIT_W | Target unit of the offered subtask |
| sub_cost | input | COST_W | Power cost of the offered subtask |
| sub_deps | input | NUM_SLOTS | Slots the offered subtask waits on |
| sub_ready | output | 1 | A free slot exists |
| sub_slot | output | SLOT_W | Slot the next offer will occupy |
| start | output | NUM_UNITS | One-cycle start pulse per unit |
| done | input | NUM_UNITS | One-cycle completion pulse per unit |
| avail | output | COST_W | Remaining power budget |

## Verification
On every cycle, the assertions check four things. At most one start fires. No start goes to a busy unit or to a subtask with pending predecessors. The running cost plus the remaining budget equals the cap, and the running cost never exceeds the cap. The cap stays fixed while anything runs. Only the bench scenarios can show ordering and timing: the replay queue overtaking a cheaper later subtask, a dependant starting the cycle after its predecessor finishes, a cap change being ignored until the block is idle, and a stray done pulse leaving the budget untouched.

// File: rtl/pwr_arb_pkg.sv
// Shared definitions for the power-budget issue arbiter.
// Assumes nothing beyond IEEE 1800-2017.
package pwr_arb_pkg;
    // Where the subtask started in a given cycle came from.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_REPLAY = 2'd1,
        SRC_FRESH  = 2'd2
    } issue_src_e;
endpackage

// File: rtl/arb_slot_table.sv
// Slot table: per slot holds occupancy, running flag, unit, cost and the
// dependency mask. Assumes a freed slot is never pushed or started in the
// same cycle (the top guarantees it by picking free slots from valid_o).
module arb_slot_table #(
    parameter int NUM_SLOTS = 4,
    parameter int UNIT_W    = 2,
    parameter int COST_W    = 6,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                push_en,
    input  logic [SLOT_W-1:0]                   push_slot,
    input  logic [UNIT_W-1:0]                   push_unit,
    input  logic [COST_W-1:0]                   push_cost,
    input  logic [NUM_SLOTS-1:0]                push_deps,
    input  logic                                start_en,
    input  logic [SLOT_W-1:0]                   start_slot,
    input  logic [NUM_SLOTS-1:0]                free_mask,
    output logic [NUM_SLOTS-1:0]                valid_o,
    output logic [NUM_SLOTS-1:0]                run_o,
    output logic [NUM_SLOTS-1:0][UNIT_W-1:0]    unit_o,
    output logic [NUM_SLOTS-1:0][COST_W-1:0]    cost_o,
    output logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] deps_o
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Per-slot state: free, load, start, and dependency clearing.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_o[s] <= 1'b0;
                run_o[s]   <= 1'b0;
                unit_o[s]  <= '0;
                cost_o[s]  <= '0;
                deps_o[s]  <= '0;
            end else if (free_mask[s]) begin
                valid_o[s] <= 1'b0;
                run_o[s]   <= 1'b0;
                deps_o[s]  <= '0;
            end else if (push_en && (push_slot == SLOT_W'(s))) begin
                valid_o[s] <= 1'b1;
                run_o[s]   <= 1'b0;
                unit_o[s]  <= push_unit;
                cost_o[s]  <= push_cost;
                deps_o[s]  <= push_deps;
            end else begin
                if (start_en && (start_slot == SLOT_W'(s)))
                    run_o[s] <= 1'b1;
                deps_o[s] <= deps_o[s] & ~free_mask;
            end
        end
    end
endmodule

// File: rtl/arb_replay_fifo.sv
// Replay queue of slot indices refused at their turn. Assumes the caller
// never pushes when full; with one entry per slot at most, DEPTH = slots
// makes that impossible.
module arb_replay_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              nonempty
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic [PTR_W-1:0]             rd_q, wr_q;
    logic [CNT_W-1:0]             cnt_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head     = mem_q[rd_q];
    assign nonempty = (cnt_q != '0);

    // Storage, pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= bump(wr_q);
            end
            if (pop)
                rd_q <= bump(rd_q);
            if (push && !pop)
                cnt_q <= cnt_q + 1'b1;
            else if (pop && !push)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/arb_budget.sv
// Budget accounting: latches the cap and the available power while idle,
// then charges starts and credits completions. Assumes take_amt never
// exceeds budget_now when take_en is high.
module arb_budget #(
    parameter int COST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic [COST_W-1:0] cap_in,
    input  logic              take_en,
    input  logic [COST_W-1:0] take_amt,
    input  logic [COST_W-1:0] give_amt,
    output logic [COST_W-1:0] budget_now,
    output logic [COST_W-1:0] avail_o,
    output logic [COST_W-1:0] cap_o
);
    // Budget seen by this cycle's issue decision.
    assign budget_now = idle ? cap_in : avail_o;

    // Cap latch while idle, and running budget update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_o   <= '0;
            avail_o <= '0;
        end else begin
            if (idle)
                cap_o <= cap_in;
            avail_o <= budget_now - (take_en ? take_amt : '0) + give_amt;
        end
    end
endmodule

// File: rtl/pwr_issue_arb.sv
// Top: power-budget subtask issue arbiter. Picks at most one subtask per
// cycle whose predecessors are gone, whose unit is idle and whose cost fits.
// The replay queue head has absolute priority. Assumes done[u] is pulsed
// only for a unit that was started (stray pulses are ignored).
module pwr_issue_arb #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_SLOTS = 4,
    parameter int COST_W    = 6,
    localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [COST_W-1:0]    cap_in,
    input  logic                 sub_valid,
    input  logic [UNIT_W-1:0]    sub_unit,
    input  logic [COST_W-1:0]    sub_cost,
    input  logic [NUM_SLOTS-1:0] sub_deps,
    output logic                 sub_ready,
    output logic [SLOT_W-1:0]    sub_slot,
    output logic [NUM_UNITS-1:0] start,
    input  logic [NUM_UNITS-1:0] done,
    output logic [COST_W-1:0]    avail
);
    import pwr_arb_pkg::*;

    logic [NUM_SLOTS-1:0]                valid_q, run_q, queued_q;
    logic [NUM_SLOTS-1:0][UNIT_W-1:0]    unit_q;
    logic [NUM_SLOTS-1:0][COST_W-1:0]    cost_q;
    logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] deps_q;
    logic [NUM_SLOTS-1:0]                free_mask, ready, fits;
    logic [NUM_UNITS-1:0]                busy;
    logic [COST_W-1:0]                   give, budget_now, cap_q;
    logic                                idle, push_en, issue_en, enq_en;
    logic                                fifo_ne;
    logic [SLOT_W-1:0]                   issue_slot, enq_slot, fifo_head;
    logic [NUM_SLOTS-1:0]                push_deps;
    issue_src_e                          src;

    // Completion decode: which slots finish, which units are busy, credit.
    always_comb begin
        free_mask = '0;
        busy      = '0;
        give      = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            free_mask[s] = run_q[s] & done[unit_q[s]];
            if (run_q[s])
                busy[unit_q[s]] = 1'b1;
            if (free_mask[s])
                give = give + cost_q[s];
        end
    end

    assign idle = ~|run_q;

    // Per-slot eligibility against dependencies, unit and budget.
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            ready[s] = valid_q[s] & ~run_q[s] & (deps_q[s] == '0)
                       & ~busy[unit_q[s]];
            fits[s]  = (cost_q[s] <= budget_now);
        end
    end

    // Issue choice: replay head only, else lowest fitting fresh slot.
    always_comb begin
        src        = SRC_NONE;
        issue_slot = '0;
        if (fifo_ne) begin
            if (ready[fifo_head] && fits[fifo_head]) begin
                src        = SRC_REPLAY;
                issue_slot = fifo_head;
            end
        end else begin
            for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
                if (ready[s] && fits[s]) begin
                    src        = SRC_FRESH;
                    issue_slot = SLOT_W'(s);
                end
            end
        end
        issue_en = (src != SRC_NONE);
    end

    // Refusal capture: lowest ready slot that must wait joins the queue.
    always_comb begin
        enq_en   = 1'b0;
        enq_slot = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (ready[s] && !queued_q[s] && (!fits[s] || fifo_ne)
                && !(issue_en && issue_slot == SLOT_W'(s))) begin
                enq_en   = 1'b1;
                enq_slot = SLOT_W'(s);
            end
        end
    end

    // Marks which slots currently sit in the replay queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            queued_q <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (enq_en && enq_slot == SLOT_W'(s))
                    queued_q[s] <= 1'b1;
                else if (src == SRC_REPLAY && issue_slot == SLOT_W'(s))
                    queued_q[s] <= 1'b0;
            end
        end
    end

    // Free-slot search and write acceptance.
    always_comb begin
        sub_slot = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--)
            if (!valid_q[s])
                sub_slot = SLOT_W'(s);
    end
    assign sub_ready = ~&valid_q;
    assign push_en   = sub_valid & sub_ready;
    assign push_deps = sub_deps & valid_q & ~free_mask;

    // Start pulse to the chosen subtask's unit.
    always_comb begin
        start = '0;
        if (issue_en)
            start[unit_q[issue_slot]] = 1'b1;
    end

    arb_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .UNIT_W    (UNIT_W),
        .COST_W    (COST_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_slot  (sub_slot),
        .push_unit  (sub_unit),
        .push_cost  (sub_cost),
        .push_deps  (push_deps),
        .start_en   (issue_en),
        .start_slot (issue_slot),
        .free_mask  (free_mask),
        .valid_o    (valid_q),
        .run_o      (run_q),
        .unit_o     (unit_q),
        .cost_o     (cost_q),
        .deps_o     (deps_q)
    );

    arb_replay_fifo #(
        .DEPTH  (NUM_SLOTS),
        .DATA_W (SLOT_W)
    ) u_replay (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_en),
        .push_data (enq_slot),
        .pop       (src == SRC_REPLAY),
        .head      (fifo_head),
        .nonempty  (fifo_ne)
    );

    arb_budget #(
        .COST_W (COST_W)
    ) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .cap_in     (cap_in),
        .take_en    (issue_en),
        .take_amt   (cost_q[issue_slot]),
        .give_amt   (give),
        .budget_now (budget_now),
        .avail_o    (avail),
        .cap_o      (cap_q)
    );
endmodule

// File: rtl/pwr_issue_chk.sv
// Checker for pwr_issue_arb, attached by bind. Observes ports and the
// state held by the slot table and the budget unit.
module pwr_issue_chk #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_SLOTS = 4,
    parameter int COST_W    = 6,
    parameter int UNIT_W    = 2,
    parameter int SLOT_W    = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [NUM_UNITS-1:0]                start,
    input logic [NUM_UNITS-1:0]                busy,
    input logic                                issue_en,
    input logic [SLOT_W-1:0]                   issue_slot,
    input logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0] deps_q,
    input logic [NUM_SLOTS-1:0]                run_q,
    input logic [NUM_SLOTS-1:0][COST_W-1:0]    cost_q,
    input logic [COST_W-1:0]                   avail,
    input logic [COST_W-1:0]                   cap_q,
    input logic                                idle
);
    logic [COST_W+SLOT_W:0] run_sum;

    // Total cost of subtasks currently running.
    always_comb begin
        run_sum = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (run_q[s])
                run_sum = run_sum + (COST_W+SLOT_W+1)'(cost_q[s]);
    end

    assert_one_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start));

    assert_idle_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start & busy) == '0);

    assert_deps_met_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> (deps_q[issue_slot] == '0));

    assert_conserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (run_sum + (COST_W+SLOT_W+1)'(avail)
                   == (COST_W+SLOT_W+1)'(cap_q)));

    assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cap_q));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_sum <= (COST_W+SLOT_W+1)'(cap_q));
endmodule

bind pwr_issue_arb pwr_issue_chk #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_SLOTS (NUM_SLOTS),
    .COST_W    (COST_W),
    .UNIT_W    (UNIT_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .issue_en   (issue_en),
    .issue_slot (issue_slot),
    .deps_q     (deps_q),
    .run_q      (run_q),
    .cost_q     (cost_q),
    .avail      (avail),
    .cap_q      (cap_q),
    .idle       (idle)
);

// File: tb/pwr_issue_arb_test.sv
// Scoreboard bench: scenarios push the expected start order into a queue;
// a monitor pops and compares every start pulse the design produces.
module pwr_issue_arb_test;
    localparam int NU = 4;
    localparam int NS = 4;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cap_in = 6'd10;
    logic          sub_valid = 1'b0;
    logic [1:0]    sub_unit = '0;
    logic [CW-1:0] sub_cost = '0;
    logic [NS-1:0] sub_deps = '0;
    logic          sub_ready;
    logic [1:0]    sub_slot;
    logic [NU-1:0] start;
    logic [NU-1:0] done = '0;
    logic [CW-1:0] avail;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string cur_req = "R1";

    pwr_issue_arb #(.NUM_UNITS(NU), .NUM_SLOTS(NS), .COST_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .sub_valid(sub_valid),
        .sub_unit(sub_unit), .sub_cost(sub_cost), .sub_deps(sub_deps),
        .sub_ready(sub_ready), .sub_slot(sub_slot), .start(start),
        .done(done), .avail(avail));

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int unit, input int cost, input int deps,
                        input bit expect_start);
        if (expect_start) exp_q.push_back(unit);
        sub_valid = 1'b1;
        sub_unit  = 2'(unit);
        sub_cost  = CW'(cost);
        sub_deps  = NS'(deps);
        @(negedge clk);
        sub_valid = 1'b0;
    endtask

    task automatic finish_unit(input int unit);
        done[unit] = 1'b1;
        @(negedge clk);
        done = '0;
    endtask

    task automatic drain(input string req);
        repeat (4) @(negedge clk);
        check(req, exp_q.size(), 0);
    endtask

    // Monitor: every start pulse must be the next expected unit.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && start != '0) begin
            int u = 0;
            for (int i = 0; i < NU; i++) if (start[i]) u = i;
            if (exp_q.size() == 0) begin
                check({cur_req, " unexpected start"}, u, -1);
            end else begin
                check({cur_req, " start order"}, u, exp_q.pop_front());
                check({"R3 one start"}, $countones(start), 1);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state.
        repeat (3) @(negedge clk);
        check("R1 start", int'(start), 0);
        check("R1 sub_ready", int'(sub_ready), 1);
        check("R1 sub_slot", int'(sub_slot), 0);
        check("R1 avail", int'(avail), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 idle load", int'(avail), 10);

        // R4/R7: slot1 waits on slot0.
        cur_req = "R4";
        push(0, 4, 0, 1);
        check("R2 slot", int'(sub_slot), 1);
        push(1, 4, 1, 0);
        repeat (5) @(negedge clk);
        check("R5 charge", int'(avail), 6);
        cur_req = "R7";
        exp_q.push_back(1);
        finish_unit(0);
        check("R7 credit", int'(avail), 10);
        drain("R7 dependant started");
        finish_unit(1);

        // R6: refused slot replayed before a cheaper later slot.
        cur_req = "R6";
        push(0, 6, 0, 1);
        push(1, 6, 0, 0);
        push(2, 3, 0, 0);
        repeat (4) @(negedge clk);
        check("R5 refused keeps budget", int'(avail), 4);
        exp_q.push_back(1);
        exp_q.push_back(2);
        finish_unit(0);
        repeat (3) @(negedge clk);
        check("R6 order budget", int'(avail), 1);
        drain("R6 drained");
        finish_unit(1);
        finish_unit(2);
        @(negedge clk);
        check("R7 all credited", int'(avail), 10);

        // R8: cap change ignored while running.
        cur_req = "R8";
        push(3, 2, 0, 1);
        @(negedge clk);
        cap_in = 6'd3;
        repeat (3) @(negedge clk);
        check("R8 ignored while busy", int'(avail), 8);
        finish_unit(3);
        repeat (2) @(negedge clk);
        check("R8 new cap", int'(avail), 3);
        push(0, 5, 0, 0);
        repeat (5) @(negedge clk);
        check("R5 over cap holds", int'(avail), 3);
        exp_q.push_back(0);
        cap_in = 6'd10;
        repeat (2) @(negedge clk);
        check("R5 charged after raise", int'(avail), 5);
        drain("R8 started");
        finish_unit(0);

        // R10: stray done ignored.
        cur_req = "R10";
        push(1, 4, 0, 1);
        repeat (2) @(negedge clk);
        finish_unit(2);
        @(negedge clk);
        check("R10 avail", int'(avail), 6);
        check("R10 slot kept", int'(sub_slot), 1);
        finish_unit(1);
        drain("R10 none pending");

        // R2/R3: fill all slots on one unit.
        cur_req = "R3";
        for (int k = 0; k < NS; k++) begin
            check("R2 lowest free", int'(sub_slot), k);
            push(3, 1, 0, 1);
        end
        check("R2 full", int'(sub_ready), 0);
        repeat (3) @(negedge clk);
        check("R3 one running", int'(avail), 9);
        for (int k = 0; k < NS; k++) begin
            finish_unit(3);
            repeat (2) @(negedge clk);
        end
        drain("R3 serial starts");
        check("R2 empty again", int'(sub_ready), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule